// File: doc/BRIEF.md
# Hardware Volume Button Controller

This block turns three active-low button or switch pins (up, down and mute) into a saturating volume level and a mute flag. Each pin passes through a two-flop synchroniser and a debounce counter whose length comes from an input, so a press counts only once the pin has stayed at its new level for that many clock ticks. An accepted up or down press moves the volume by one step. A held button repeats after a longer first delay and then at a fixed interval.

A 2-bit format field selects one of four ways to read the buttons. In the level scheme the mute pin acts as a switch. In the toggling scheme it acts as a momentary button. In the chord scheme the mute pin is unused and pressing up and down together mutes. In the last scheme the up pin is unused and the mute pin does the work of up, with chords as in the third scheme. A separate enable bit gates all of this. Both fields are loaded through a one-cycle configuration write strobe.

To tell a chord from a single press, the block waits a short window after the first accepted press before it acts. A single press therefore changes the volume after that window, or at once if the button is released inside it.

Top module: `hvb_ctrl`

## Requirements
- R1: After reset, the volume is VOL_RESET (32 by default), mute is 0, the enable bit is 0 and the format is level-switch (00).
- R2: A configuration write sets the enable bit from cfg_wdata[2] and the format from cfg_wdata[1:0]. While the enable bit is 0, no pin activity changes the volume or the mute flag.
- R3: A pin is accepted as pressed only after it has been low for dbnc_ticks consecutive synchronised cycles. A shorter low pulse has no effect.
- R4: Each accepted step raises or lowers the volume by exactly one. The volume saturates at 0 and at 63 and never wraps.
- R5: A held up or down button produces one step after the chord window (WIN_TICKS). It then repeats once after REP_DLY cycles and every REP_IVL cycles after that, until the button is released.
- R6: In format 00 the mute flag follows the debounced mute pin: it is 1 while the pin is held low and 0 while the pin is high.
- R7: In format 01 each accepted press of the mute pin toggles the mute flag.
- R8: In format 01 any accepted up or down press clears the mute flag. When a mute press and an up or down press are accepted in the same cycle, the clear wins and the flag ends at 0.
- R9: In format 10 the mute pin is ignored. Pressing up and down together sets the mute flag and leaves the volume unchanged. A later single up or down step clears the mute flag.
- R10: In format 11 the up pin is ignored and the mute pin steps the volume up. Pressing mute and down together sets the mute flag without a volume change.
- R11: A configuration write that changes the format clears the mute flag.
- R12: In formats 10 and 11, a second button accepted within WIN_TICKS cycles of the first forms a chord. A second button accepted later than that is ignored while the first is still held, and the first button steps normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_up_n | input | 1 | Up button, active low, asynchronous |
| btn_dn_n | input | 1 | Down button, active low, asynchronous |
| btn_mute_n | input | 1 | Mute button or switch, active low, asynchronous |
| dbnc_ticks | input | DBW | Debounce length in clock ticks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Bit 2 is the enable; bits 1:0 are the format |
| vol_o | output | VOL_W | Current volume level |
| mute_o | output | 1 | Mute flag |

## Verification
In the toggling format, a mute-toggle press and an up press can be accepted on the same clock edge. Each wants to drive the mute flag a different way. The bench provokes this by driving both pins low on the same cycle from an un-muted start: their synchronisers and debounce counters line up, so both presses are accepted together. The result is judged by requiring mute to stay 0 and the volume to rise by one. Chord detection is also driven on both sides of its window, with a second press staggered by 3 cycles and by 25 cycles.

// File: rtl/hvb_pkg.sv
package hvb_pkg;
   typedef enum logic [1:0] {
      FMT_LEVEL  = 2'b00,
      FMT_TOGGLE = 2'b01,
      FMT_CHORD  = 2'b10,
      FMT_MUP    = 2'b11
   } hvb_fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PEND,
      ST_HOLD,
      ST_CHORD
   } hvb_st_e;

   localparam int PIN_UP   = 0;
   localparam int PIN_DN   = 1;
   localparam int PIN_MUTE = 2;
   localparam int NUM_PINS = 3;
endpackage

// File: rtl/hvb_debounce.sv
module hvb_debounce #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_n,
   input  logic [CNT_W-1:0] limit,
   output logic             held,
   output logic             press
);
   logic             sync1, sync2, held_d;
   logic [CNT_W-1:0] cnt;
   logic             lvl;

   assign lvl = ~sync2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1  <= 1'b1;
         sync2  <= 1'b1;
         cnt    <= '0;
         held   <= 1'b0;
         held_d <= 1'b0;
      end else begin
         sync1  <= pin_n;
         sync2  <= sync1;
         held_d <= held;
         if (lvl != held) begin
            if (({1'b0, cnt} + 1'b1) >= {1'b0, limit}) begin
               held <= lvl;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end

   assign press = held & ~held_d;
endmodule

// File: rtl/hvb_stepper.sv
module hvb_stepper
   import hvb_pkg::*;
#(
   parameter int WIN     = 8,
   parameter int REP_DLY = 40,
   parameter int REP_IVL = 10,
   parameter int TW      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic chord_en,
   input  logic up_held,
   input  logic up_press,
   input  logic dn_held,
   input  logic dn_press,
   output logic step_up,
   output logic step_dn,
   output logic chord
);
   localparam logic [TW-1:0] WIN_M1 = TW'(WIN - 1);
   localparam logic [TW-1:0] DLY_M1 = TW'(REP_DLY - 1);
   localparam logic [TW-1:0] IVL_M1 = TW'(REP_IVL - 1);

   hvb_st_e       st_q, st_d;
   logic          dir_q, dir_d;
   logic          first_q, first_d;
   logic [TW-1:0] tmr_q, tmr_d;
   logic          fire, own_held, other_press;

   assign own_held    = dir_q ? up_held  : dn_held;
   assign other_press = dir_q ? dn_press : up_press;

   always_comb begin
      st_d    = st_q;
      dir_d   = dir_q;
      first_d = first_q;
      tmr_d   = tmr_q;
      fire    = 1'b0;
      chord   = 1'b0;
      if (!en || clr) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (chord_en && up_press && dn_press) begin
                  chord = 1'b1;
                  st_d  = ST_CHORD;
               end else if (up_press || dn_press) begin
                  st_d  = ST_PEND;
                  dir_d = up_press;
                  tmr_d = '0;
               end
            end
            ST_PEND: begin
               if (chord_en && other_press) begin
                  chord = 1'b1;
                  st_d  = ST_CHORD;
               end else if (!own_held) begin
                  fire = 1'b1;
                  st_d = ST_IDLE;
               end else if (tmr_q == WIN_M1) begin
                  fire    = 1'b1;
                  st_d    = ST_HOLD;
                  tmr_d   = '0;
                  first_d = 1'b1;
               end else begin
                  tmr_d = tmr_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (!own_held) begin
                  st_d = ST_IDLE;
               end else if (tmr_q == (first_q ? DLY_M1 : IVL_M1)) begin
                  fire    = 1'b1;
                  tmr_d   = '0;
                  first_d = 1'b0;
               end else begin
                  tmr_d = tmr_q + 1'b1;
               end
            end
            default: begin
               if (!up_held && !dn_held) st_d = ST_IDLE;
            end
         endcase
      end
   end

   assign step_up = fire & dir_q;
   assign step_dn = fire & ~dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         dir_q   <= 1'b0;
         first_q <= 1'b0;
         tmr_q   <= '0;
      end else begin
         st_q    <= st_d;
         dir_q   <= dir_d;
         first_q <= first_d;
         tmr_q   <= tmr_d;
      end
   end
endmodule

// File: rtl/hvb_ctrl.sv
module hvb_ctrl
   import hvb_pkg::*;
#(
   parameter int VOL_W     = 6,
   parameter int VOL_RESET = 32,
   parameter int DBW       = 8,
   parameter int WIN_TICKS = 8,
   parameter int REP_DLY   = 40,
   parameter int REP_IVL   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn_up_n,
   input  logic             btn_dn_n,
   input  logic             btn_mute_n,
   input  logic [DBW-1:0]   dbnc_ticks,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_wdata,
   output logic [VOL_W-1:0] vol_o,
   output logic             mute_o
);
   localparam int TMAX = (REP_DLY > WIN_TICKS) ?
                         ((REP_DLY > REP_IVL) ? REP_DLY : REP_IVL) :
                         ((WIN_TICKS > REP_IVL) ? WIN_TICKS : REP_IVL);
   localparam int TW = $clog2(TMAX) + 1;
   localparam logic [VOL_W-1:0] VMAX = '1;

   if (VOL_W < 2 || VOL_W > 16) begin : g_bad_vol_w
      $error("hvb_ctrl: VOL_W out of range");
   end
   if (VOL_RESET < 0 || VOL_RESET > (2**VOL_W) - 1) begin : g_bad_vol_reset
      $error("hvb_ctrl: VOL_RESET outside volume range");
   end
   if (WIN_TICKS < 1 || REP_DLY < 1 || REP_IVL < 1) begin : g_bad_timing
      $error("hvb_ctrl: timing parameters must be positive");
   end

   logic [NUM_PINS-1:0] pins_n, held, press;
   assign pins_n = {btn_mute_n, btn_dn_n, btn_up_n};

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      hvb_debounce #(.CNT_W(DBW)) u_dbnc (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_n (pins_n[g]),
         .limit (dbnc_ticks),
         .held  (held[g]),
         .press (press[g])
      );
   end

   logic             en_q, mute_r;
   hvb_fmt_e         fmt_q;
   logic [VOL_W-1:0] vol_q;
   logic             mute_held, mute_press;
   logic             up_src_held, up_src_press;
   logic             step_up, step_dn, chord;

   assign mute_held    = held[PIN_MUTE];
   assign mute_press   = press[PIN_MUTE];
   assign up_src_held  = (fmt_q == FMT_MUP) ? held[PIN_MUTE]  : held[PIN_UP];
   assign up_src_press = (fmt_q == FMT_MUP) ? press[PIN_MUTE] : press[PIN_UP];

   hvb_stepper #(
      .WIN     (WIN_TICKS),
      .REP_DLY (REP_DLY),
      .REP_IVL (REP_IVL),
      .TW      (TW)
   ) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .clr      (cfg_we),
      .chord_en (fmt_q[1]),
      .up_held  (up_src_held),
      .up_press (up_src_press),
      .dn_held  (held[PIN_DN]),
      .dn_press (press[PIN_DN]),
      .step_up  (step_up),
      .step_dn  (step_dn),
      .chord    (chord)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         fmt_q  <= FMT_LEVEL;
         mute_r <= 1'b0;
      end else if (cfg_we) begin
         en_q  <= cfg_wdata[2];
         fmt_q <= hvb_fmt_e'(cfg_wdata[1:0]);
         if (hvb_fmt_e'(cfg_wdata[1:0]) != fmt_q) mute_r <= 1'b0;
      end else if (en_q) begin
         case (fmt_q)
            FMT_LEVEL:  mute_r <= mute_held;
            FMT_TOGGLE: begin
               if (up_src_press || press[PIN_DN]) mute_r <= 1'b0;
               else if (mute_press)               mute_r <= ~mute_r;
            end
            default: begin
               if (chord)                   mute_r <= 1'b1;
               else if (step_up || step_dn) mute_r <= 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_q <= VOL_W'(VOL_RESET);
      end else if (step_up && vol_q != VMAX) begin
         vol_q <= vol_q + 1'b1;
      end else if (step_dn && vol_q != '0) begin
         vol_q <= vol_q - 1'b1;
      end
   end

   assign vol_o  = vol_q;
   assign mute_o = mute_r;
endmodule

// File: rtl/hvb_ctrl_chk.sv
module hvb_ctrl_chk #(
   parameter int VOL_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [VOL_W-1:0] vol_o,
   input logic             mute_o,
   input logic             cfg_we,
   input logic [2:0]       cfg_wdata,
   input logic             en_q,
   input logic [1:0]       fmt_q,
   input logic             mute_held
);
   localparam logic [VOL_W-1:0] VMAX = '1;

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_o != $past(vol_o)) |->
         (vol_o == $past(vol_o) + 1'b1 || vol_o == $past(vol_o) - 1'b1));

   assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_o == VMAX) |=> (vol_o != '0));

   assert_no_wrap_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_o == '0) |=> (vol_o != VMAX));

   assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_q) |-> $stable(vol_o));

   assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == 2'b00 && $past(fmt_q) == 2'b00 && $past(en_q) && !$past(cfg_we))
         |-> (mute_o == $past(mute_held)));

   assert_chord_no_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mute_o) && fmt_q[1] && $past(fmt_q[1])) |-> $stable(vol_o));

   assert_fmt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[1:0] != fmt_q) |=> !mute_o);
endmodule

bind hvb_ctrl hvb_ctrl_chk #(.VOL_W(VOL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vol_o     (vol_o),
   .mute_o    (mute_o),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .en_q      (en_q),
   .fmt_q     (fmt_q),
   .mute_held (mute_held)
);

// File: tb/hvb_ctrl_bench.sv
module hvb_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       up_n = 1'b1, dn_n = 1'b1, mu_n = 1'b1;
   logic [7:0] dbnc = 8'd4;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_wdata = 3'b000;
   logic [5:0] vol;
   logic       mute;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   hvb_ctrl u_hvb_ctrl (
      .clk (clk), .rst_n (rst_n),
      .btn_up_n (up_n), .btn_dn_n (dn_n), .btn_mute_n (mu_n),
      .dbnc_ticks (dbnc), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
      .vol_o (vol), .mute_o (mute)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cfg(logic en, logic [1:0] fmt);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = {en, fmt};
      @(negedge clk);
      cfg_we = 1'b0;
      wait_cyc(2);
   endtask

   // drive chosen pins low together for cyc cycles, then release and settle
   task automatic push(logic u, logic d, logic m, int cyc);
      @(negedge clk);
      up_n = ~u; dn_n = ~d; mu_n = ~m;
      wait_cyc(cyc);
      up_n = 1'b1; dn_n = 1'b1; mu_n = 1'b1;
      wait_cyc(30);
   endtask

   task automatic t_reset;
      check("R1 volume after reset", vol, 32);
      check("R1 mute after reset", mute, 0);
   endtask

   task automatic t_disabled;
      push(1, 0, 0, 20);
      check("R2 up ignored while disabled", vol, 32);
      push(0, 0, 1, 20);
      check("R2 mute pin ignored while disabled", mute, 0);
   endtask

   task automatic t_glitch;
      push(1, 0, 0, 2);
      check("R3 short pulse ignored", vol, 32);
   endtask

   task automatic t_steps;
      push(1, 0, 0, 20);
      check("R4 single up step", vol, 33);
      push(0, 1, 0, 20);
      check("R4 single down step", vol, 32);
   endtask

   task automatic t_repeat;
      int d;
      push(1, 0, 0, 120);
      d = int'(vol) - 32;
      n_chk++;
      if (d < 7 || d > 9) begin
         n_bad++;
         $display("FAIL R5 auto-repeat steps: actual %0d expected 7..9", d);
      end
      push(1, 0, 0, 700);
      check("R4 saturate at 63", vol, 63);
      push(0, 1, 0, 900);
      check("R4 saturate at 0", vol, 0);
      push(0, 1, 0, 20);
      check("R4 no wrap below 0", vol, 0);
      push(1, 0, 0, 20);
      check("R4 step up from 0", vol, 1);
   endtask

   task automatic t_level;
      @(negedge clk);
      mu_n = 1'b0;
      wait_cyc(20);
      check("R6 muted while pin low", mute, 1);
      mu_n = 1'b1;
      wait_cyc(20);
      check("R6 unmuted while pin high", mute, 0);
   endtask

   task automatic t_toggle;
      wr_cfg(1'b1, 2'b01);
      push(0, 0, 1, 20);
      check("R7 first toggle", mute, 1);
      push(0, 0, 1, 20);
      check("R7 second toggle", mute, 0);
      push(0, 0, 1, 20);
      check("R7 third toggle", mute, 1);
      push(1, 0, 0, 20);
      check("R8 up clears mute", mute, 0);
      check("R8 up still steps", vol, 2);
      push(1, 0, 1, 20);
      check("R8 same-cycle mute and up: clear wins", mute, 0);
      check("R8 same-cycle volume", vol, 3);
      push(0, 0, 1, 20);
      check("R11 muted before format change", mute, 1);
      wr_cfg(1'b1, 2'b10);
      check("R11 format change clears mute", mute, 0);
   endtask

   task automatic t_chord;
      push(1, 1, 0, 20);
      check("R9 chord mutes", mute, 1);
      check("R9 chord leaves volume", vol, 3);
      push(0, 0, 1, 20);
      check("R9 mute pin ignored", mute, 1);
      push(1, 0, 0, 20);
      check("R9 single up unmutes", mute, 0);
      check("R9 single up steps", vol, 4);
      // second button 3 cycles after the first: inside window
      @(negedge clk); up_n = 1'b0;
      wait_cyc(3); dn_n = 1'b0;
      wait_cyc(20); up_n = 1'b1; dn_n = 1'b1;
      wait_cyc(30);
      check("R12 staggered chord mutes", mute, 1);
      check("R12 staggered chord volume", vol, 4);
      // second button 25 cycles later: outside window
      @(negedge clk); up_n = 1'b0;
      wait_cyc(25); dn_n = 1'b0;
      wait_cyc(10); up_n = 1'b1; dn_n = 1'b1;
      wait_cyc(30);
      check("R12 late second press not a chord", mute, 0);
      check("R12 late press first button stepped", vol, 5);
   endtask

   task automatic t_mup;
      wr_cfg(1'b1, 2'b11);
      push(1, 0, 0, 20);
      check("R10 up pin ignored", vol, 5);
      push(0, 0, 1, 20);
      check("R10 mute pin steps up", vol, 6);
      push(0, 1, 1, 20);
      check("R10 mute+down chord mutes", mute, 1);
      check("R10 chord volume", vol, 6);
      push(0, 1, 0, 20);
      check("R10 down unmutes", mute, 0);
      check("R10 down steps", vol, 5);
      wr_cfg(1'b0, 2'b11);
      push(0, 0, 1, 20);
      check("R2 disabled again", vol, 5);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_disabled();
      wr_cfg(1'b1, 2'b00);
      t_glitch();
      t_steps();
      t_repeat();
      t_level();
      t_toggle();
      t_chord();
      t_mup();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule